// File: doc/BRIEF.md
# Software-Managed Translation Buffer Register Port

This block holds the entries of a set-associative translation lookaside buffer and the three control registers that system software uses to inspect and fill it. A page-address register holds a virtual page number (VPN). A control register holds a process identifier (PID), a way selector, a read trigger and a write-enable flag. A payload register holds the translation data. Software reads an entry by setting the read trigger. It fills an entry by writing the payload register while the write-enable flag is set. After each fill the way selector moves on by one, so a handler that only writes payloads spreads its fills across the ways.

The low bits of the VPN choose the line and the way selector chooses the way. The upper VPN bits and the PID form the stored tag. The exception logic raises the write-enable flag when it reports a permission fault. It also raises the flag when it reports a miss while the handler-active status is clear. The register contents do not follow changes to the selectors: they change only through their own writes or through an explicit read.

Top module: `tlb_sw_access`

## Requirements
- R1: After reset all registers read zero and every entry is invalid. Reading an invalid entry returns zero for the tag bits, the PID and the payload.
- R2: An entry is addressed by the low log2(NUM_LINES) bits of the VPN register (the line) together with the way selector. Its tag is the remaining upper VPN bits plus the PID.
- R3: A control write with the read bit set loads three values from the addressed entry, visible on the next cycle: the VPN tag bits, the PID and the payload. The entry is addressed by the current VPN line and the way value written in that same control write. The VPN line bits are kept.
- R4: Writing the VPN, the way or the PID without a read leaves the payload register unchanged. Each read-back field changes only through its own write or through a read.
- R5: A payload write with the write-enable flag at 0 updates only the payload register. No entry is written and the way selector does not move.
- R6: A payload write with the write-enable flag at 1 stores the current VPN tag bits, the PID and the written payload into the addressed entry. It also advances the way selector by one.
- R7: The way selector counts modulo NUM_WAYS. A written way value is reduced modulo NUM_WAYS, so for a power-of-two way count the unused upper bits are dropped.
- R8: The write-enable flag is set on a permission fault, or on a miss while the handler-active input is 0. A miss with handler-active at 1 has no effect. A hardware set wins over a software clear in the same cycle.
- R9: Apart from hardware sets, the write-enable flag changes only through control-register writes, which load it from the write-enable bit.
- R10: On a read, the PID from the entry wins over a PID written in the same cycle, and the payload from the entry wins over a same-cycle payload write.
- R11: A way value written by software wins over the automatic advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pte_wr | input | 1 | Write strobe for the VPN register |
| pte_wdata | input | VPN_W | New VPN value |
| misc_wr | input | 1 | Write strobe for the control register |
| misc_pid | input | PID_W | PID value to write |
| misc_way | input | WAY_FIELD_W | Way value to write |
| misc_rd | input | 1 | Read trigger, acts only with misc_wr |
| misc_we | input | 1 | Write-enable value to write |
| acc_wr | input | 1 | Write strobe for the payload register |
| acc_wdata | input | DATA_W | Payload value to write |
| exc_perm | input | 1 | Permission-fault report |
| exc_miss | input | 1 | Miss report |
| exc_in_handler | input | 1 | Handler-active status bit |
| vpn_q | output | VPN_W | VPN register |
| pid_q | output | PID_W | PID register |
| way_q | output | WAY_FIELD_W | Way selector, zero-extended |
| we_q | output | 1 | Write-enable flag |
| acc_q | output | DATA_W | Payload register |

## Verification
The bench goes after the cycles where two writers collide. These are a read together with a PID or payload write, a software way write together with an advancing fill, and a software flag clear together with a fault report. A design with the wrong priority would show the software value where the entry's value or the hardware value is expected. The bench also fills past the last way and checks the wrap. A counter that wrapped on the field width instead of the way count would land on a nonexistent way. Stale-register cases follow: selector changes without a read must leave the payload alone, and a design that read continuously would track the new selection at once. Random traffic at the end reads entries written many cycles earlier, which catches indexing that swaps line and way bits.

// File: rtl/tlb_sw_pkg.sv
// Shared helpers for the translation buffer register port.
// Assumes nothing beyond integer parameters of at least 1.
package tlb_sw_pkg;

    // Index width for n items, never below one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Whether an exception report raises the write-enable flag.
    function automatic logic we_trigger(input logic perm, input logic miss,
                                        input logic in_handler);
        return perm | (miss & ~in_handler);
    endfunction

endpackage

// File: rtl/tlb_entry_store.sv
// Entry storage: one bank per way, each bank NUM_LINES deep, one
// combinational read port and one synchronous write port.
// Assumes NUM_LINES is a power of two. An invalid entry reads as zeros.
module tlb_entry_store #(
    parameter int NUM_WAYS  = 4,
    parameter int NUM_LINES = 16,
    parameter int TAG_W     = 16,
    parameter int PID_W     = 8,
    parameter int DATA_W    = 24,
    parameter int WAY_W     = 2,
    parameter int LINE_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [LINE_W-1:0] rd_line,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [PID_W-1:0]  rd_pid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [PID_W-1:0]  wr_pid,
    input  logic [DATA_W-1:0] wr_data
);
    logic [TAG_W-1:0]  tag_by_way  [NUM_WAYS];
    logic [PID_W-1:0]  pid_by_way  [NUM_WAYS];
    logic [DATA_W-1:0] data_by_way [NUM_WAYS];

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic              valid_m [NUM_LINES];
        logic [TAG_W-1:0]  tag_m   [NUM_LINES];
        logic [PID_W-1:0]  pid_m   [NUM_LINES];
        logic [DATA_W-1:0] data_m  [NUM_LINES];

        // Clear the bank on reset, store one entry per fill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int l = 0; l < NUM_LINES; l++) begin
                    valid_m[l] <= 1'b0;
                    tag_m[l]   <= '0;
                    pid_m[l]   <= '0;
                    data_m[l]  <= '0;
                end
            end else if (wr_en && (int'(wr_way) == w)) begin
                valid_m[wr_line] <= 1'b1;
                tag_m[wr_line]   <= wr_tag;
                pid_m[wr_line]   <= wr_pid;
                data_m[wr_line]  <= wr_data;
            end
        end

        // Present this bank's line, masked to zero when invalid.
        always_comb begin
            tag_by_way[w]  = valid_m[rd_line] ? tag_m[rd_line]  : '0;
            pid_by_way[w]  = valid_m[rd_line] ? pid_m[rd_line]  : '0;
            data_by_way[w] = valid_m[rd_line] ? data_m[rd_line] : '0;
        end
    end

    // Select the addressed way.
    always_comb begin
        rd_tag  = tag_by_way[rd_way];
        rd_pid  = pid_by_way[rd_way];
        rd_data = data_by_way[rd_way];
    end

endmodule

// File: rtl/tlb_way_ctrl.sv
// Way selector: loaded by software, advanced by one after each fill,
// wrapping at NUM_WAYS. Software load wins over advance.
// Assumes the caller reduces loaded values below NUM_WAYS.
module tlb_way_ctrl #(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_load,
    input  logic [WAY_W-1:0] sw_way,
    input  logic             advance,
    output logic [WAY_W-1:0] way
);
    localparam logic [WAY_W-1:0] LAST = WAY_W'(NUM_WAYS - 1);

    // Hold, load or step the selector.
    always_ff @(posedge clk) begin
        if (!rst_n)
            way <= '0;
        else if (sw_load)
            way <= sw_way;
        else if (advance)
            way <= (way == LAST) ? '0 : way + 1'b1;
    end

endmodule

// File: rtl/tlb_we_flag.sv
// Write-enable flag: loaded by software, forced to one by qualifying
// exception reports, which win over a same-cycle software load.
module tlb_we_flag
    import tlb_sw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_load,
    input  logic sw_we,
    input  logic exc_perm,
    input  logic exc_miss,
    input  logic exc_in_handler,
    output logic we
);
    // Apply hardware set first, then software load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            we <= 1'b0;
        else if (we_trigger(exc_perm, exc_miss, exc_in_handler))
            we <= 1'b1;
        else if (sw_load)
            we <= sw_we;
    end

endmodule

// File: rtl/tlb_sw_access.sv
// Top of the software register port of a set-associative translation
// buffer. Holds the VPN, PID and payload registers and wires the entry
// store, the way selector and the write-enable flag.
// Assumes NUM_LINES and NUM_WAYS are powers of two, NUM_WAYS <= 16,
// PID_W in 8..14 and VPN_W > log2(NUM_LINES).
module tlb_sw_access
    import tlb_sw_pkg::*;
#(
    parameter int NUM_WAYS    = 4,
    parameter int NUM_LINES   = 16,
    parameter int PID_W       = 8,
    parameter int VPN_W       = 20,
    parameter int DATA_W      = 24,
    parameter int WAY_FIELD_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pte_wr,
    input  logic [VPN_W-1:0]       pte_wdata,
    input  logic                   misc_wr,
    input  logic [PID_W-1:0]       misc_pid,
    input  logic [WAY_FIELD_W-1:0] misc_way,
    input  logic                   misc_rd,
    input  logic                   misc_we,
    input  logic                   acc_wr,
    input  logic [DATA_W-1:0]      acc_wdata,
    input  logic                   exc_perm,
    input  logic                   exc_miss,
    input  logic                   exc_in_handler,
    output logic [VPN_W-1:0]       vpn_q,
    output logic [PID_W-1:0]       pid_q,
    output logic [WAY_FIELD_W-1:0] way_q,
    output logic                   we_q,
    output logic [DATA_W-1:0]      acc_q
);
    localparam int WAY_W  = idx_w(NUM_WAYS);
    localparam int LINE_W = idx_w(NUM_LINES);
    localparam int TAG_W  = VPN_W - LINE_W;

    logic [WAY_W-1:0]  way_r;
    logic [WAY_W-1:0]  way_sel;
    logic              rd_fire;
    logic              fill;
    logic [TAG_W-1:0]  rd_tag;
    logic [PID_W-1:0]  rd_pid;
    logic [DATA_W-1:0] rd_data;

    // Decode the strobes and reduce the written way modulo the way count.
    always_comb begin
        rd_fire = misc_wr & misc_rd;
        fill    = acc_wr & we_q;
        way_sel = WAY_W'(misc_way % WAY_FIELD_W'(NUM_WAYS));
    end

    tlb_entry_store #(
        .NUM_WAYS (NUM_WAYS),
        .NUM_LINES(NUM_LINES),
        .TAG_W    (TAG_W),
        .PID_W    (PID_W),
        .DATA_W   (DATA_W),
        .WAY_W    (WAY_W),
        .LINE_W   (LINE_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_way (way_sel),
        .rd_line(vpn_q[LINE_W-1:0]),
        .rd_tag (rd_tag),
        .rd_pid (rd_pid),
        .rd_data(rd_data),
        .wr_en  (fill),
        .wr_way (way_r),
        .wr_line(vpn_q[LINE_W-1:0]),
        .wr_tag (vpn_q[VPN_W-1:LINE_W]),
        .wr_pid (pid_q),
        .wr_data(acc_wdata)
    );

    tlb_way_ctrl #(
        .NUM_WAYS(NUM_WAYS),
        .WAY_W   (WAY_W)
    ) u_way (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_load(misc_wr),
        .sw_way (way_sel),
        .advance(fill),
        .way    (way_r)
    );

    tlb_we_flag u_we (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_load       (misc_wr),
        .sw_we         (misc_we),
        .exc_perm      (exc_perm),
        .exc_miss      (exc_miss),
        .exc_in_handler(exc_in_handler),
        .we            (we_q)
    );

    // VPN: line bits follow software only, tag bits take a read first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vpn_q <= '0;
        else begin
            if (pte_wr)
                vpn_q[LINE_W-1:0] <= pte_wdata[LINE_W-1:0];
            if (rd_fire)
                vpn_q[VPN_W-1:LINE_W] <= rd_tag;
            else if (pte_wr)
                vpn_q[VPN_W-1:LINE_W] <= pte_wdata[VPN_W-1:LINE_W];
        end
    end

    // PID: a read wins over a same-cycle software write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pid_q <= '0;
        else if (rd_fire)
            pid_q <= rd_pid;
        else if (misc_wr)
            pid_q <= misc_pid;
    end

    // Payload: a read wins over a same-cycle software write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (rd_fire)
            acc_q <= rd_data;
        else if (acc_wr)
            acc_q <= acc_wdata;
    end

    assign way_q = WAY_FIELD_W'(way_r);

endmodule

// File: rtl/tlb_sw_access_chk.sv
// Temporal checks on the port of tlb_sw_access, attached by bind.
module tlb_sw_access_chk #(
    parameter int NUM_WAYS    = 4,
    parameter int PID_W       = 8,
    parameter int VPN_W       = 20,
    parameter int DATA_W      = 24,
    parameter int WAY_FIELD_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pte_wr,
    input logic                   misc_wr,
    input logic                   misc_rd,
    input logic                   acc_wr,
    input logic [DATA_W-1:0]      acc_wdata,
    input logic                   exc_perm,
    input logic                   exc_miss,
    input logic                   exc_in_handler,
    input logic [VPN_W-1:0]       vpn_q,
    input logic [PID_W-1:0]       pid_q,
    input logic [WAY_FIELD_W-1:0] way_q,
    input logic                   we_q,
    input logic [DATA_W-1:0]      acc_q
);
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pte_wr && !misc_wr && !acc_wr) |=>
        ($stable(vpn_q) && $stable(pid_q) && $stable(acc_q)));

    // R5
    no_fill_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && !we_q && !misc_wr) |=> $stable(way_q));

    // R6
    fill_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && we_q && !misc_wr) |=>
        (way_q == WAY_FIELD_W'((int'($past(way_q)) + 1) % NUM_WAYS)));

    // R7
    way_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(way_q) < NUM_WAYS);

    // R8
    we_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_perm || (exc_miss && !exc_in_handler)) |=> we_q);

    // R9
    we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!misc_wr && !exc_perm && !(exc_miss && !exc_in_handler)) |=>
        $stable(we_q));

    // R10
    acc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && !(misc_wr && misc_rd)) |=> (acc_q == $past(acc_wdata)));

endmodule

bind tlb_sw_access tlb_sw_access_chk #(
    .NUM_WAYS   (NUM_WAYS),
    .PID_W      (PID_W),
    .VPN_W      (VPN_W),
    .DATA_W     (DATA_W),
    .WAY_FIELD_W(WAY_FIELD_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pte_wr        (pte_wr),
    .misc_wr       (misc_wr),
    .misc_rd       (misc_rd),
    .acc_wr        (acc_wr),
    .acc_wdata     (acc_wdata),
    .exc_perm      (exc_perm),
    .exc_miss      (exc_miss),
    .exc_in_handler(exc_in_handler),
    .vpn_q         (vpn_q),
    .pid_q         (pid_q),
    .way_q         (way_q),
    .we_q          (we_q),
    .acc_q         (acc_q)
);

// File: tb/tlb_sw_access_tb.sv
`timescale 1ns/1ps
module tlb_sw_access_tb;
    localparam int NW = 4, NL = 16, PW = 8, VW = 20, DW = 24, WF = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pte_wr = 0, misc_wr = 0, misc_rd = 0, misc_we = 0, acc_wr = 0;
    logic exc_perm = 0, exc_miss = 0, exc_in_handler = 0;
    logic [VW-1:0] pte_wdata = '0;
    logic [PW-1:0] misc_pid = '0;
    logic [WF-1:0] misc_way = '0;
    logic [DW-1:0] acc_wdata = '0;
    logic [VW-1:0] vpn_q;
    logic [PW-1:0] pid_q;
    logic [WF-1:0] way_q;
    logic          we_q;
    logic [DW-1:0] acc_q;

    always #2 clk = ~clk;

    tlb_sw_access #(.NUM_WAYS(NW), .NUM_LINES(NL), .PID_W(PW), .VPN_W(VW),
                    .DATA_W(DW), .WAY_FIELD_W(WF)) u_dut (.*);

    // Behavioural reference state.
    int m_vpn, m_pid, m_way, m_we, m_acc;
    int e_val [NW][NL];
    int e_tag [NW][NL];
    int e_pid [NW][NL];
    int e_dat [NW][NL];
    int total = 0, bad = 0;
    bit done = 0;
    string req = "R1";

    task automatic chk(string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("vpn", int'(vpn_q), m_vpn);
        chk("pid", int'(pid_q), m_pid);
        chk("way", int'(way_q), m_way);
        chk("we",  int'(we_q),  m_we);
        chk("acc", int'(acc_q), m_acc);
    endtask

    task automatic model_reset();
        m_vpn = 0; m_pid = 0; m_way = 0; m_we = 0; m_acc = 0;
        for (int w = 0; w < NW; w++)
            for (int l = 0; l < NL; l++) begin
                e_val[w][l] = 0; e_tag[w][l] = 0; e_pid[w][l] = 0; e_dat[w][l] = 0;
            end
    endtask

    // Advance one clock: update model from the held inputs, then compare.
    task automatic step();
        int nv, np, nw, ne, na, line, rw;
        @(posedge clk);
        nv = m_vpn; np = m_pid; nw = m_way; ne = m_we; na = m_acc;
        line = m_vpn % NL;
        if (pte_wr) nv = int'(pte_wdata);
        if (misc_wr) begin
            np = int'(misc_pid); nw = int'(misc_way) % NW; ne = int'(misc_we);
        end
        if (acc_wr) na = int'(acc_wdata);
        if (misc_wr && misc_rd) begin
            rw = int'(misc_way) % NW;
            nv = (e_val[rw][line] ? e_tag[rw][line] * NL : 0) + (nv % NL);
            np = e_val[rw][line] ? e_pid[rw][line] : 0;
            na = e_val[rw][line] ? e_dat[rw][line] : 0;
        end
        if (acc_wr && m_we != 0) begin
            e_val[m_way][line] = 1;
            e_tag[m_way][line] = m_vpn / NL;
            e_pid[m_way][line] = m_pid;
            e_dat[m_way][line] = int'(acc_wdata);
            if (!misc_wr) nw = (m_way + 1) % NW;
        end
        if (exc_perm || (exc_miss && !exc_in_handler)) ne = 1;
        m_vpn = nv; m_pid = np; m_way = nw; m_we = ne; m_acc = na;
        @(negedge clk);
        if (rst_n) compare();
    endtask

    task automatic idle();
        pte_wr = 0; misc_wr = 0; misc_rd = 0; acc_wr = 0;
        exc_perm = 0; exc_miss = 0; exc_in_handler = 0;
    endtask

    task automatic set_vpn(int v);
        pte_wr = 1; pte_wdata = VW'(v); step(); idle();
    endtask

    task automatic set_misc(int pid, int way, bit rd, bit we);
        misc_wr = 1; misc_pid = PW'(pid); misc_way = WF'(way);
        misc_rd = rd; misc_we = we; step(); idle();
    endtask

    task automatic put_acc(int d);
        acc_wr = 1; acc_wdata = DW'(d); step(); idle();
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        req = "R1"; compare();                       // R1 reset values
        req = "R1"; set_misc(0, 2, 1, 0);            // R1 invalid entry reads zero
        req = "R5"; put_acc(24'h0abcde);             // R5 payload only, no fill
        req = "R5"; set_misc(0, 0, 1, 0);            // R5 entry still empty
        req = "R9"; set_misc(8'h35, 0, 0, 1);        // R9 software sets flag
        req = "R6"; set_vpn(20'h12343);
        for (int i = 0; i < 5; i++) put_acc(24'h100000 + i);  // R6/R7 fills and wrap
        req = "R7"; set_misc(8'h35, 4'hE, 0, 1);     // R7 upper bits dropped -> way 2
        req = "R2"; set_vpn(20'h00003);
        for (int w = 0; w < NW; w++) set_misc(0, w, 1, 1);   // R2/R3 read back each way
        req = "R3"; set_vpn(20'h00005);
        req = "R3"; set_misc(0, 0, 1, 1);            // R3 other line is empty
        req = "R4"; set_vpn(20'h77773);              // R4 no read: payload stale
        req = "R4"; set_misc(8'h11, 1, 0, 1);
        req = "R10"; set_misc(8'h99, 1, 1, 1);       // R10 entry PID beats written PID
        req = "R10";
        misc_wr = 1; misc_rd = 1; misc_way = 2; misc_pid = 8'h44; misc_we = 0;
        acc_wr = 1; acc_wdata = 24'h555555; step(); idle();  // R10 read beats payload
        req = "R11"; set_misc(8'h21, 0, 0, 1);
        misc_wr = 1; misc_way = 3; misc_we = 1; misc_rd = 0;
        acc_wr = 1; acc_wdata = 24'h777777; step(); idle();  // R11 software way wins
        req = "R8"; set_misc(0, 0, 0, 0);
        exc_miss = 1; exc_in_handler = 1; step(); idle();    // R8 masked miss
        exc_miss = 1; step(); idle();                        // R8 miss sets
        set_misc(0, 0, 0, 0);
        exc_perm = 1; exc_in_handler = 1; step(); idle();    // R8 fault sets
        misc_wr = 1; misc_we = 0; exc_perm = 1; step(); idle(); // R8 hw beats clear
        req = "R9"; set_misc(0, 1, 0, 0);                     // R9 software clear
        req = "R2";
        for (int i = 0; i < 600; i++) begin                  // R2 random traffic
            pte_wr = $urandom_range(0, 3) == 0;
            pte_wdata = VW'($urandom);
            misc_wr = $urandom_range(0, 3) == 0;
            misc_rd = $urandom_range(0, 1) == 0;
            misc_we = $urandom_range(0, 2) != 0;
            misc_pid = PW'($urandom);
            misc_way = WF'($urandom);
            acc_wr = $urandom_range(0, 2) == 0;
            acc_wdata = DW'($urandom);
            exc_perm = $urandom_range(0, 15) == 0;
            exc_miss = $urandom_range(0, 15) == 0;
            exc_in_handler = $urandom_range(0, 1) == 0;
            step();
        end
        idle();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule